// File: doc/BRIEF.md
# Asynchronous Strobe FIFO Port

This block is the device side of a parallel byte port. An external agent with no clock shared with the chip reads and writes it through two active-low strobes, a read strobe and a write strobe, over an 8-bit data path. Inside the chip there are two byte queues. The receive queue is filled from the internal side through a valid/ready handshake, and its bytes are handed out on the bus. The transmit queue collects bytes written by the external agent and offers them to internal logic through a second valid/ready handshake.

Two active-low flags tell the external agent when it may act. The read-available flag is low while a byte is waiting to be read. The write-allowed flag is low while the transmit queue can take a byte. Both strobes pass through two-flop synchronisers into the internal clock, and their edges are found there.

A read works in two steps. The falling edge of the read strobe presents the oldest byte on the bus. The rising edge retires that byte. After every read the read-available flag goes high for a settling gap, and it comes back low only if another byte is waiting. A write captures the bus when the falling edge of the write strobe is seen. A write that arrives while writes are not allowed is dropped, and a sticky overflow indication is set.

Top module: `strobe_fifo_port`

## Requirements
- R1: After reset `rxf_n`=1, `txe_n`=0, `bus_oe`=0, `overflow`=0, `out_valid`=0 and `in_ready`=1.
- R2: `bus_oe` is 1 while the synchronised read strobe is low and 0 while it is high; it falls within three clock edges of `rd_n` rising.
- R3: With the read strobe idle and the settling gap over, `rxf_n` is 0 exactly when the receive queue holds at least one byte.
- R4: A read strobe taken while `rxf_n`=0 presents on `bus_out` the oldest byte queued on the internal side, in arrival order, by the third clock edge after `rd_n` falls.
- R5: When a read strobe rises, `rxf_n` is 1 for at least SETTLE (at least 2) cycles after the third clock edge, and afterwards it is 0 only if another byte remains.
- R6: A read strobe that falls while `rxf_n`=1 removes no byte: the next accepted read returns the byte that would have been returned without it.
- R7: On a falling edge of `wr_n`, while `txe_n`=0, the value of `bus_in` is placed in the transmit queue, and these bytes appear on `out_data`/`out_valid` in write order.
- R8: `txe_n` is 1 from the third clock edge after an accepted write falls, holds for at least SETTLE (at least 2) cycles, and stays 1 while the transmit queue holds TX_DEPTH bytes.
- R9: A write strobe that falls while `txe_n`=1 leaves the transmit queue unchanged and sets `overflow`, which stays 1 until reset.
- R10: Each strobe passes through two flops, so `bus_oe` equals the inverse of `rd_n` as sampled two clock edges earlier; one edge after a strobe falls no output has reacted.
- R11: `in_ready` is 0 while the receive queue holds RX_DEPTH bytes, and a byte offered then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_n | input | 1 | Asynchronous read strobe, active low |
| wr_n | input | 1 | Asynchronous write strobe, active low |
| bus_in | input | 8 | Data bus as seen by the port's receivers |
| bus_out | output | 8 | Data the port places on the bus |
| bus_oe | output | 1 | Bus driver enable, high while reading |
| rxf_n | output | 1 | Low when a byte can be read |
| txe_n | output | 1 | Low when a byte can be written |
| overflow | output | 1 | Sticky flag for a write that was refused |
| in_data | input | 8 | Byte offered to the receive queue |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Receive queue can take a byte |
| out_data | output | 8 | Oldest byte in the transmit queue |
| out_valid | output | 1 | Transmit queue holds a byte |
| out_ready | input | 1 | Internal consumer takes `out_data` |

## Verification
The properties assume that each strobe stays at each level for at least three clock cycles, that both strobes are held high during reset, that `bus_in` is steady while the write strobe is low, and that no new read strobe falls during the settling gap. The stimulus changes every input on the falling clock edge. Each strobe is held low for four cycles and high for longer than the gap plus the synchroniser delay, and the bus value is set together with the falling write strobe. Randomised operations are issued one at a time, each finishing before the next begins, so the internal handshakes never overlap a strobe in a way the assumptions exclude.

// File: rtl/sfp_pkg.sv
`timescale 1ns/1ps
package sfp_pkg;

    // read-side controller states
    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_ACTIVE = 2'd1,
        RD_REJECT = 2'd2,
        RD_GAP    = 2'd3
    } rd_state_e;

    // indices of the strobes in the synchroniser array
    localparam int STB_RD  = 0;
    localparam int STB_WR  = 1;
    localparam int STB_NUM = 2;

    // settling periods are never shorter than two cycles
    function automatic int settle_len(input int req);
        return (req < 2) ? 2 : req;
    endfunction

    // pointer width with one wrap bit
    function automatic int ptr_bits(input int depth);
        return $clog2(depth) + 1;
    endfunction

endpackage

// File: rtl/sfp_strobe_sync.sv
`timescale 1ns/1ps
module sfp_strobe_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic low_now,
    output logic low_prev
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= pin_n;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign low_now  = ~s2_q;
    assign low_prev = ~s3_q;
endmodule

// File: rtl/sfp_fifo.sv
`timescale 1ns/1ps
module sfp_fifo import sfp_pkg::*; #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    input  logic         out_ready
);
    localparam int PW = ptr_bits(DEPTH);
    localparam int AW = PW - 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic          full, empty, do_push, do_pop;

    assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    assign empty   = (wp_q == rp_q);
    assign do_push = in_valid & ~full;
    assign do_pop  = out_ready & ~empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + PW'(1);
            if (do_pop)  rp_q <= rp_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q[AW-1:0]] <= in_data;
    end

    assign in_ready  = ~full;
    assign out_valid = ~empty;
    assign out_data  = mem[rp_q[AW-1:0]];
endmodule

// File: rtl/sfp_read_ctl.sv
`timescale 1ns/1ps
module sfp_read_ctl import sfp_pkg::*; #(
    parameter int W      = 8,
    parameter int SETTLE = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb_low,
    input  logic         stb_low_d,
    input  logic         byte_avail,
    input  logic [W-1:0] byte_data,
    output logic         pop,
    output logic         rxf_n,
    output logic [W-1:0] drive_data
);
    localparam int GAP = settle_len(SETTLE);
    localparam int CW  = $clog2(GAP + 1);

    rd_state_e     st_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  hold_q;
    logic          fall, rise;

    assign fall = stb_low & ~stb_low_d;
    assign rise = ~stb_low & stb_low_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RD_IDLE;
            cnt_q  <= '0;
            hold_q <= '0;
        end else begin
            case (st_q)
                RD_IDLE: begin
                    if (fall) begin
                        if (byte_avail) begin
                            st_q   <= RD_ACTIVE;
                            hold_q <= byte_data;
                        end else begin
                            st_q <= RD_REJECT;
                        end
                    end
                end
                RD_ACTIVE, RD_REJECT: begin
                    if (rise) begin
                        st_q  <= RD_GAP;
                        cnt_q <= CW'(GAP);
                    end
                end
                RD_GAP: begin
                    if (cnt_q == CW'(1)) st_q <= RD_IDLE;
                    else                 cnt_q <= cnt_q - CW'(1);
                end
                default: st_q <= RD_IDLE;
            endcase
        end
    end

    assign pop        = (st_q == RD_ACTIVE) & rise;
    assign rxf_n      = ~(((st_q == RD_IDLE) & byte_avail) | (st_q == RD_ACTIVE));
    assign drive_data = hold_q;
endmodule

// File: rtl/sfp_write_ctl.sv
`timescale 1ns/1ps
module sfp_write_ctl import sfp_pkg::*; #(
    parameter int W      = 8,
    parameter int SETTLE = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb_low,
    input  logic         stb_low_d,
    input  logic [W-1:0] bus_in,
    input  logic         fifo_full,
    output logic         push,
    output logic [W-1:0] push_data,
    output logic         txe_n,
    output logic         overflow
);
    localparam int HOLD = settle_len(SETTLE);
    localparam int CW   = $clog2(HOLD + 1);

    logic [CW-1:0] hold_q;
    logic          ovf_q, fall;

    assign fall      = stb_low & ~stb_low_d;
    assign txe_n     = (hold_q != '0) | fifo_full;
    assign push      = fall & ~txe_n;
    assign push_data = bus_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (push)                hold_q <= CW'(HOLD);
            else if (hold_q != '0)   hold_q <= hold_q - CW'(1);
            if (fall & txe_n)        ovf_q  <= 1'b1;
        end
    end

    assign overflow = ovf_q;
endmodule

// File: rtl/strobe_fifo_port.sv
`timescale 1ns/1ps
module strobe_fifo_port import sfp_pkg::*; #(
    parameter int W        = 8,
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4,
    parameter int SETTLE   = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic         rxf_n,
    output logic         txe_n,
    output logic         overflow,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    input  logic         out_ready
);
    logic [STB_NUM-1:0] pins_n, low_now, low_prev;

    assign pins_n[STB_RD] = rd_n;
    assign pins_n[STB_WR] = wr_n;

    for (genvar g = 0; g < STB_NUM; g++) begin : g_sync
        sfp_strobe_sync sync_i (
            .clk      (clk),
            .rst      (rst),
            .pin_n    (pins_n[g]),
            .low_now  (low_now[g]),
            .low_prev (low_prev[g])
        );
    end

    // receive path: internal side -> queue -> bus
    logic [W-1:0] rxq_data;
    logic         rxq_valid, rx_pop;

    sfp_fifo #(.W(W), .DEPTH(RX_DEPTH)) rxq_i (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (rxq_data),
        .out_valid (rxq_valid),
        .out_ready (rx_pop)
    );

    sfp_read_ctl #(.W(W), .SETTLE(SETTLE)) rdc_i (
        .clk        (clk),
        .rst        (rst),
        .stb_low    (low_now[STB_RD]),
        .stb_low_d  (low_prev[STB_RD]),
        .byte_avail (rxq_valid),
        .byte_data  (rxq_data),
        .pop        (rx_pop),
        .rxf_n      (rxf_n),
        .drive_data (bus_out)
    );

    assign bus_oe = low_now[STB_RD];

    // transmit path: bus -> queue -> internal side
    logic [W-1:0] txq_wdata;
    logic         tx_push, txq_ready;

    sfp_write_ctl #(.W(W), .SETTLE(SETTLE)) wrc_i (
        .clk       (clk),
        .rst       (rst),
        .stb_low   (low_now[STB_WR]),
        .stb_low_d (low_prev[STB_WR]),
        .bus_in    (bus_in),
        .fifo_full (~txq_ready),
        .push      (tx_push),
        .push_data (txq_wdata),
        .txe_n     (txe_n),
        .overflow  (overflow)
    );

    sfp_fifo #(.W(W), .DEPTH(TX_DEPTH)) txq_i (
        .clk       (clk),
        .rst       (rst),
        .in_data   (txq_wdata),
        .in_valid  (tx_push),
        .in_ready  (txq_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );
endmodule

// File: rtl/sfp_port_checker.sv
`timescale 1ns/1ps
module sfp_port_checker (
    input logic clk,
    input logic rst,
    input logic rd_n,
    input logic bus_oe,
    input logic rxf_n,
    input logic txe_n,
    input logic overflow
);
    // R10: driver enable follows the read strobe through exactly two flops
    p_oe_two_flop_r10: assert property (@(posedge clk) disable iff (rst)
        bus_oe == !$past(rd_n, 2));

    // R2: the driver is only enabled after the strobe has been low for a while
    p_oe_needs_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> !$past(rd_n, 1));

    // R5: a read flag that goes high stays high for more than one cycle
    p_rxf_gap_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rxf_n) |=> rxf_n);

    // R8: the write flag holds high for more than one cycle once raised
    p_txe_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(txe_n) |=> txe_n);

    // R9: overflow is sticky
    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind strobe_fifo_port sfp_port_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .rd_n     (rd_n),
    .bus_oe   (bus_oe),
    .rxf_n    (rxf_n),
    .txe_n    (txe_n),
    .overflow (overflow)
);

// File: tb/strobe_fifo_port_tb_top.sv
`timescale 1ns/1ps
module strobe_fifo_port_tb_top;
    localparam int W        = 8;
    localparam int RX_DEPTH = 4;
    localparam int TX_DEPTH = 4;
    localparam int SETTLE   = 2;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rd_n = 1'b1, wr_n = 1'b1;
    logic [W-1:0] bus_in = '0, in_data = '0;
    logic         in_valid = 1'b0, out_ready = 1'b0;
    logic [W-1:0] bus_out, out_data;
    logic         bus_oe, rxf_n, txe_n, overflow, in_ready, out_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit ovf_model = 1'b0;
    logic [W-1:0] rx_q[$];
    logic [W-1:0] tx_q[$];

    always #2.5 clk = ~clk;

    strobe_fifo_port #(.W(W), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .SETTLE(SETTLE)) dut_i (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .rxf_n(rxf_n), .txe_n(txe_n),
        .overflow(overflow), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    function automatic logic exp_rxf_n(input int n);
        return (n == 0);
    endfunction

    function automatic logic exp_txe_n(input int n);
        return (n >= TX_DEPTH);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_rx(input logic [W-1:0] b);
        @(negedge clk);
        chk("R11 in_ready", 32'(in_ready), 32'(rx_q.size() < RX_DEPTH));
        if (rx_q.size() < RX_DEPTH) rx_q.push_back(b);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R3 rxf after push", 32'(rxf_n), 32'(exp_rxf_n(rx_q.size())));
    endtask

    task automatic do_read();
        bit take;
        take = (rx_q.size() != 0);
        @(negedge clk);
        chk("R3 rxf before read", 32'(rxf_n), 32'(exp_rxf_n(rx_q.size())));
        rd_n = 1'b0;
        @(negedge clk);
        chk("R10 no reaction after one edge", 32'(bus_oe), 32'(0));
        @(negedge clk);
        @(negedge clk);
        chk("R2 oe while reading", 32'(bus_oe), 32'(1));
        if (take) begin
            chk("R4 read data", 32'(bus_out), 32'(rx_q[0]));
            chk("R3 rxf held in read", 32'(rxf_n), 32'(0));
        end else begin
            chk("R6 rejected read keeps rxf high", 32'(rxf_n), 32'(1));
        end
        @(negedge clk);
        rd_n = 1'b1;
        if (take) void'(rx_q.pop_front());
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R2 oe released", 32'(bus_oe), 32'(0));
        chk("R5 rxf gap first", 32'(rxf_n), 32'(1));
        @(negedge clk);
        chk("R5 rxf gap second", 32'(rxf_n), 32'(1));
        @(negedge clk);
        @(negedge clk);
        chk("R5 rxf after gap", 32'(rxf_n), 32'(exp_rxf_n(rx_q.size())));
    endtask

    task automatic do_write(input logic [W-1:0] b);
        bit take;
        @(negedge clk);
        chk("R8 txe before write", 32'(txe_n), 32'(exp_txe_n(tx_q.size())));
        take = (tx_q.size() < TX_DEPTH);
        wr_n   = 1'b0;
        bus_in = b;
        if (take) tx_q.push_back(b);
        else      ovf_model = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R8 txe high after write", 32'(txe_n), 32'(1));
        @(negedge clk);
        wr_n   = 1'b1;
        bus_in = W'($urandom);
        repeat (SETTLE + 4) @(negedge clk);
        chk("R8 txe settled", 32'(txe_n), 32'(exp_txe_n(tx_q.size())));
        chk("R9 overflow", 32'(overflow), 32'(ovf_model));
    endtask

    task automatic drain_tx();
        @(negedge clk);
        while (tx_q.size() != 0) begin
            chk("R7 out_valid", 32'(out_valid), 32'(1));
            chk("R7 out_data order", 32'(out_data), 32'(tx_q[0]));
            out_ready = 1'b1;
            @(negedge clk);
            void'(tx_q.pop_front());
        end
        out_ready = 1'b0;
        chk("R7 queue empty", 32'(out_valid), 32'(0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rxf_n", 32'(rxf_n), 32'(1));
        chk("R1 txe_n", 32'(txe_n), 32'(0));
        chk("R1 bus_oe", 32'(bus_oe), 32'(0));
        chk("R1 overflow", 32'(overflow), 32'(0));
        chk("R1 out_valid", 32'(out_valid), 32'(0));
        chk("R1 in_ready", 32'(in_ready), 32'(1));

        // R6: read with nothing queued, then make sure no byte was lost
        do_read();
        push_rx(8'hA5);
        do_read();

        // R4 ordering, R5 flag return between bytes
        push_rx(8'h11);
        push_rx(8'h22);
        push_rx(8'h33);
        do_read();
        do_read();
        do_read();

        // R11: fill receive queue and offer one more
        for (int i = 0; i < RX_DEPTH + 1; i++) push_rx(W'(8'h40 + i));
        for (int i = 0; i < RX_DEPTH; i++) do_read();

        // R7/R8: fill transmit queue; R9: extra write refused
        for (int i = 0; i < TX_DEPTH; i++) do_write(W'(8'hC0 + i));
        do_write(8'hEE);
        drain_tx();

        // randomised mix
        for (int it = 0; it < 80; it++) begin
            case ($urandom_range(0, 3))
                0: push_rx(W'($urandom));
                1: do_read();
                2: do_write(W'($urandom));
                default: drain_tx();
            endcase
        end
        while (rx_q.size() != 0) do_read();
        drain_tx();
        chk("R9 overflow still set", 32'(overflow), 32'(1));
        finish_run();
    end
endmodule